// File: doc/BRIEF.md
# Floating-Point Compare and Min/Max Unit

This unit orders two IEEE-754 operands, either both single precision or both double precision. It returns a one-bit predicate for the equal, greater-than and greater-or-equal tests, and a full-width operand for minimum and maximum. A pipeline issues one operation per cycle with a valid strobe, an opcode and a precision select. The predicate or the selected word appears on registered outputs one cycle later.

NaN handling does not follow IEEE. A compare that involves a NaN is simply false and stays quiet. A min or max with a single NaN operand passes the other operand through. When both operands are NaN, the result is the all-ones word. Only double-precision min/max reports a NaN: it sets the invalid flag.

The unit owns a sticky status register with five exception flags. Software can overwrite that register through a write strobe.

Top module: `fp_cmpsel_unit`

## Requirements
- R1: An operation presented with `inValid` high at a rising edge makes `outValid` high after that edge, and `outResult` and `outPred` show its outcome. In a cycle with `inValid` low, `outValid` goes low and `outResult` and `outPred` keep their values.
- R2: Opcode encodings on `opSel`:
  - 0 is equal, 1 is greater-than, 2 is greater-or-equal, 3 is minimum and 4 is maximum.
  - Codes 5 to 7 give a zero result, a false predicate and no flag.
  - With `isDouble`=1 the operands use all 64 bits. With `isDouble`=0 only bits 31:0 are used, bits 63:32 of the operands are ignored, and the result is zero-extended.
- R3: For non-NaN operands, ordering follows the sign-magnitude value, and infinities lie beyond every finite value. A compare drives its answer on `outPred` with `outResult` zero. A min/max drives `outPred` low.
- R4: +0 and -0 compare equal. Minimum of the two zeros returns -0 and maximum returns +0.
- R5: Any compare that has a NaN operand returns false and sets no flag, in either precision.
- R6: A min/max with exactly one NaN operand returns the other operand bit for bit.
- R7: A min/max with two NaN operands returns all ones: 0xFFFFFFFF for single precision and 0xFFFFFFFFFFFFFFFF for double precision.
- R8: A single-precision min/max never sets a status flag, NaN or not.
- R9: A double-precision min/max with at least one NaN operand sets the invalid flag (bit 1).
- R10: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. Patterns with the quiet bit clear (0x7F800001) count as NaN. Infinity (exponent all ones, fraction zero) is not a NaN.
- R11: Status register layout and update rules:
  - Bit layout of `stsFlags`: bit 1 invalid, bit 2 divide-by-zero, bit 3 overflow, bit 4 underflow, bit 5 inexact. Bit 0 always reads 0.
  - Flags are sticky: without a write, no bit ever clears.
  - `stsWrEn` replaces bits 5:1 with `stsWrData[5:1]` at the edge.
  - When a write and a flag-raising operation share an edge, the written value is ORed with the new flag.
- R12: While `rstN` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| opSel | input | 3 | Opcode |
| isDouble | input | 1 | 1 = 64-bit operands, 0 = 32-bit |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| stsWrEn | input | 1 | Status write strobe |
| stsWrData | input | 6 | Status write value (bit 0 ignored) |
| outValid | output | 1 | Result valid |
| outPred | output | 1 | Compare predicate |
| outResult | output | 64 | Min/max result, zero for compares |
| stsFlags | output | 6 | Sticky status flags |

## Verification
The operand pairs cover a range of cases:
- Ordered values of mixed sign, including infinities against finite values. These separate sign-magnitude ordering from plain unsigned or two's-complement ordering.
- The zero pair, which shows whether the sign is honoured on a tie.
- Quiet NaNs, signalling-style NaNs and infinities, each in one or both operand positions and in both precisions. These tell the NaN classifier from an exponent-only check, and single-precision quiet behaviour from the double-precision invalid flag.
- Garbage in the upper operand bits, reserved opcodes, and status writes alone, overlapping an operation, and following one. These show that the ignored inputs are ignored, and that the sticky and replace semantics are kept apart.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;
  localparam logic [2:0] OP_EQ  = 3'd0;
  localparam logic [2:0] OP_GT  = 3'd1;
  localparam logic [2:0] OP_GE  = 3'd2;
  localparam logic [2:0] OP_MIN = 3'd3;
  localparam logic [2:0] OP_MAX = 3'd4;

  localparam int FLAG_W   = 6;
  localparam int FLAG_INV = 1;
  localparam logic [FLAG_W-1:0] FLAG_MASK = 6'b111110;

  typedef struct packed {
    logic       capture;
    logic       isDouble;
    logic [2:0] op;
  } fpcs_ctrl_t;
endpackage

// File: rtl/fpcs_order.sv
module fpcs_order #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         aNan,
  output logic         bNan,
  output logic         eq,
  output logic         gt
);
  logic [W-2:0] magA, magB;
  logic sA, sB;

  assign sA   = a[W-1];
  assign sB   = b[W-1];
  assign magA = a[W-2:0];
  assign magB = b[W-2:0];

  assign aNan = (&a[W-2:FRAC_W]) && (|a[FRAC_W-1:0]);
  assign bNan = (&b[W-2:FRAC_W]) && (|b[FRAC_W-1:0]);

  always_comb begin
    eq = (magA == '0 && magB == '0) || (a == b);
    if (eq)            gt = 1'b0;
    else if (sA != sB) gt = !sA;
    else if (!sA)      gt = magA > magB;
    else               gt = magA < magB;
  end
endmodule

// File: rtl/fpcs_datapath.sv
module fpcs_datapath
  import fpcs_pkg::*;
#(
  parameter int SGL_EXP  = 8,
  parameter int SGL_FRAC = 23,
  parameter int DBL_EXP  = 11,
  parameter int DBL_FRAC = 52,
  localparam int SGL_W   = 1 + SGL_EXP + SGL_FRAC,
  localparam int DATA_W  = 1 + DBL_EXP + DBL_FRAC
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpcs_ctrl_t        ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              anyNan,
  output logic [DATA_W-1:0] resultQ,
  output logic              predQ
);
  logic [DATA_W-1:0] fmtMin [2];
  logic [DATA_W-1:0] fmtMax [2];
  logic              fmtEq  [2];
  logic              fmtGt  [2];
  logic              fmtNan [2];

  for (genvar g = 0; g < 2; g++) begin : g_fmt
    localparam int EW = (g == 1) ? DBL_EXP  : SGL_EXP;
    localparam int FWD = (g == 1) ? DBL_FRAC : SGL_FRAC;
    localparam int FW = 1 + EW + FWD;
    logic [FW-1:0] a, b, mn, mx;
    logic aNan, bNan, eq, gt;

    assign a = opA[FW-1:0];
    assign b = opB[FW-1:0];

    fpcs_order #(.EXP_W(EW), .FRAC_W(FWD)) u_order (
      .a(a), .b(b), .aNan(aNan), .bNan(bNan), .eq(eq), .gt(gt)
    );

    always_comb begin
      if (aNan && bNan) begin
        mn = '1;
        mx = '1;
      end else if (aNan) begin
        mn = b;
        mx = b;
      end else if (bNan) begin
        mn = a;
        mx = a;
      end else if (gt) begin
        mn = b;
        mx = a;
      end else if (eq) begin
        mn = a[FW-1] ? a : b;
        mx = a[FW-1] ? b : a;
      end else begin
        mn = a;
        mx = b;
      end
    end

    assign fmtMin[g] = DATA_W'(mn);
    assign fmtMax[g] = DATA_W'(mx);
    assign fmtEq[g]  = eq;
    assign fmtGt[g]  = gt;
    assign fmtNan[g] = aNan || bNan;
  end

  logic              selNan, selEq, selGt;
  logic [DATA_W-1:0] nxtRes;
  logic              nxtPred;

  assign selNan = fmtNan[ctrl.isDouble];
  assign selEq  = fmtEq[ctrl.isDouble];
  assign selGt  = fmtGt[ctrl.isDouble];
  assign anyNan = selNan;

  always_comb begin
    nxtRes  = '0;
    nxtPred = 1'b0;
    case (ctrl.op)
      OP_EQ:  nxtPred = !selNan && selEq;
      OP_GT:  nxtPred = !selNan && selGt;
      OP_GE:  nxtPred = !selNan && (selGt || selEq);
      OP_MIN: nxtRes  = fmtMin[ctrl.isDouble];
      OP_MAX: nxtRes  = fmtMax[ctrl.isDouble];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      predQ   <= 1'b0;
    end else if (ctrl.capture) begin
      resultQ <= nxtRes;
      predQ   <= nxtPred;
    end
  end

  logic unusedSgl;
  assign unusedSgl = (SGL_W > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/fpcs_control.sv
module fpcs_control
  import fpcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opSel,
  input  logic              isDouble,
  input  logic              stsWrEn,
  input  logic [FLAG_W-1:0] stsWrData,
  input  logic              anyNan,
  output fpcs_ctrl_t        ctrl,
  output logic              outValid,
  output logic [FLAG_W-1:0] stsFlags
);
  logic              invalidHit;
  logic [FLAG_W-1:0] stsQ, stsBase, raised;

  assign ctrl.capture  = inValid;
  assign ctrl.isDouble = isDouble;
  assign ctrl.op       = opSel;

  assign invalidHit = inValid && isDouble && anyNan &&
                      (opSel == OP_MIN || opSel == OP_MAX);
  assign raised  = FLAG_W'(invalidHit) << FLAG_INV;
  assign stsBase = stsWrEn ? (stsWrData & FLAG_MASK) : stsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsQ     <= '0;
      outValid <= 1'b0;
    end else begin
      stsQ     <= stsBase | raised;
      outValid <= inValid;
    end
  end

  assign stsFlags = stsQ;
endmodule

// File: rtl/fp_cmpsel_unit.sv
module fp_cmpsel_unit
  import fpcs_pkg::*;
#(
  parameter int SGL_EXP  = 8,
  parameter int SGL_FRAC = 23,
  parameter int DBL_EXP  = 11,
  parameter int DBL_FRAC = 52
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  opSel,
  input  logic        isDouble,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic        stsWrEn,
  input  logic [5:0]  stsWrData,
  output logic        outValid,
  output logic        outPred,
  output logic [63:0] outResult,
  output logic [5:0]  stsFlags
);
  fpcs_ctrl_t ctrl;
  logic       anyNan;

  fpcs_control u_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .isDouble(isDouble), .stsWrEn(stsWrEn), .stsWrData(stsWrData),
    .anyNan(anyNan), .ctrl(ctrl), .outValid(outValid), .stsFlags(stsFlags)
  );

  fpcs_datapath #(
    .SGL_EXP(SGL_EXP), .SGL_FRAC(SGL_FRAC),
    .DBL_EXP(DBL_EXP), .DBL_FRAC(DBL_FRAC)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB),
    .anyNan(anyNan), .resultQ(outResult), .predQ(outPred)
  );
endmodule

// File: rtl/fpcs_checker.sv
module fpcs_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [2:0]  opSel,
  input logic        isDouble,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic        stsWrEn,
  input logic        outValid,
  input logic        outPred,
  input logic [63:0] outResult,
  input logic [5:0]  stsFlags
);
  logic nanA, nanB, isMinMax, isCmp;

  always_comb begin
    if (isDouble) begin
      nanA = (opA[62:52] == 11'h7FF) && (opA[51:0] != 52'd0);
      nanB = (opB[62:52] == 11'h7FF) && (opB[51:0] != 52'd0);
    end else begin
      nanA = (opA[30:23] == 8'hFF) && (opA[22:0] != 23'd0);
      nanB = (opB[30:23] == 8'hFF) && (opB[22:0] != 23'd0);
    end
  end
  assign isMinMax = (opSel == 3'd3) || (opSel == 3'd4);
  assign isCmp    = (opSel <= 3'd2);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r3_minmax_pred_low: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isMinMax) |=> !outPred);
  a_r5_nan_compare_false: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isCmp && (nanA || nanB)) |=> !outPred);
  a_r7_dbl_canonical: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isDouble && isMinMax && nanA && nanB) |=> (outResult == 64'hFFFF_FFFF_FFFF_FFFF));
  a_r8_single_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isDouble && !stsWrEn) |=> $stable(stsFlags));
  a_r9_dbl_invalid: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isDouble && isMinMax && (nanA || nanB)) |=> stsFlags[1]);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !stsWrEn |=> (($past(stsFlags) & ~stsFlags) == 6'd0));
endmodule

bind fp_cmpsel_unit fpcs_checker u_fpcs_checker (.*);

// File: tb/fp_cmpsel_unit_bench.sv
module fp_cmpsel_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic        isDouble = 1'b0;
  logic [63:0] opA = 64'd0;
  logic [63:0] opB = 64'd0;
  logic        stsWrEn = 1'b0;
  logic [5:0]  stsWrData = 6'd0;
  logic        outValid, outPred;
  logic [63:0] outResult;
  logic [5:0]  stsFlags;

  int checks = 0;
  int fails  = 0;
  bit running = 0;
  string curTag = "R1";

  fp_cmpsel_unit u_fp_cmpsel_unit (.*);

  always #10 clk = ~clk;

  localparam logic [63:0] S_ONE = 64'h3F80_0000, S_TWO = 64'h4000_0000;
  localparam logic [63:0] S_NEG1 = 64'hBF80_0000, S_QNAN = 64'h7FC0_0000;
  localparam logic [63:0] S_SNAN = 64'h7F80_0001, S_INF = 64'h7F80_0000;
  localparam logic [63:0] S_NINF = 64'hFF80_0000, S_NZ = 64'h8000_0000;
  localparam logic [63:0] D_ONE = 64'h3FF0_0000_0000_0000, D_ANY = 64'h3F80_0000_0000_0000;
  localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000, D_SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] D_INF = 64'h7FF0_0000_0000_0000, D_NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] D_NEG2 = 64'hC000_0000_0000_0000;

  // behavioural reference state
  logic        expValid = 0, expPred = 0;
  logic [63:0] expRes = 0;
  logic [5:0]  expSts = 0;
  string       expTag = "R12";

  function automatic bit isNan(bit dbl, logic [63:0] v);
    if (dbl) return v[62:52] == 11'h7FF && v[51:0] != 0;
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction

  function automatic longint keyOf(bit dbl, logic [63:0] v);
    longint mag;
    bit s;
    mag = dbl ? longint'(v[62:0]) : longint'(v[30:0]);
    s   = dbl ? v[63] : v[31];
    return s ? -mag : mag;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expValid = 0; expPred = 0; expRes = 0; expSts = 0; expTag = "R12";
    end else begin
      logic [63:0] a, b, ones;
      bit na, nb, inv;
      longint ka, kb;
      a = isDouble ? opA : {32'd0, opA[31:0]};
      b = isDouble ? opB : {32'd0, opB[31:0]};
      ones = isDouble ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      na = isNan(isDouble, a); nb = isNan(isDouble, b);
      ka = keyOf(isDouble, a); kb = keyOf(isDouble, b);
      inv = 0;
      expValid = inValid;
      if (inValid) begin
        expTag = curTag;
        expRes = 0; expPred = 0;
        case (opSel)
          3'd0: expPred = !na && !nb && ka == kb;
          3'd1: expPred = !na && !nb && ka > kb;
          3'd2: expPred = !na && !nb && ka >= kb;
          3'd3, 3'd4: begin
            if (na && nb) expRes = ones;
            else if (na) expRes = b;
            else if (nb) expRes = a;
            else if (ka == kb) begin
              if (opSel == 3'd3) expRes = (isDouble ? a[63] : a[31]) ? a : b;
              else expRes = (isDouble ? a[63] : a[31]) ? b : a;
            end else if ((ka < kb) == (opSel == 3'd3)) expRes = a;
            else expRes = b;
            inv = isDouble && (na || nb);
          end
          default: ;
        endcase
      end else if (stsWrEn) expTag = curTag;
      if (stsWrEn) expSts = stsWrData & 6'b111110;
      if (inv) expSts[1] = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (running) begin
      checks++;
      if ({outValid, outPred, outResult, stsFlags} !== {expValid, expPred, expRes, expSts}) begin
        fails++;
        $display("FAIL %s: actual v=%0b p=%0b r=%h s=%b expected v=%0b p=%0b r=%h s=%b",
                 expTag, outValid, outPred, outResult, stsFlags,
                 expValid, expPred, expRes, expSts);
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic dbl,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    opSel = op; isDouble = dbl; opA = a; opB = b; inValid = 1'b1; curTag = tag;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic writeSts(input logic [5:0] d, input string tag);
    stsWrEn = 1'b1; stsWrData = d; curTag = tag;
    @(negedge clk);
    stsWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    curTag = "R1";
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({outValid, outPred, outResult, stsFlags} !== '0) begin
      fails++;
      $display("FAIL R12: actual %h expected 0", {outValid, outPred, outResult, stsFlags});
    end
    rstN = 1'b1;
    running = 1;
    @(negedge clk);
    // R3 ordering, single and double
    issue(3'd0, 0, S_ONE, S_ONE, "R3");
    issue(3'd1, 0, S_TWO, S_ONE, "R3");
    issue(3'd1, 0, S_NEG1, S_ONE, "R3");
    issue(3'd2, 0, S_NEG1, S_NEG1, "R3");
    issue(3'd1, 0, S_INF, S_TWO, "R3");
    issue(3'd1, 0, S_NINF, S_NEG1, "R3");
    issue(3'd3, 0, S_NEG1, S_TWO, "R3");
    issue(3'd4, 0, S_NEG1, S_TWO, "R3");
    issue(3'd1, 1, D_NEG2, D_ONE, "R3");
    issue(3'd4, 1, D_INF, D_ONE, "R3");
    issue(3'd3, 1, D_NEG2, D_ANY, "R3");
    idle(2);
    // R4 signed zeros
    issue(3'd0, 0, 64'd0, S_NZ, "R4");
    issue(3'd3, 0, 64'd0, S_NZ, "R4");
    issue(3'd4, 0, S_NZ, 64'd0, "R4");
    issue(3'd3, 1, 64'd0, D_NZ, "R4");
    issue(3'd4, 1, D_NZ, 64'd0, "R4");
    // R5 NaN compares are false and quiet
    issue(3'd0, 0, S_QNAN, S_ONE, "R5");
    issue(3'd1, 0, S_QNAN, S_ONE, "R5");
    issue(3'd2, 0, S_ONE, S_QNAN, "R5");
    issue(3'd0, 1, D_QNAN, D_ANY, "R5");
    issue(3'd1, 1, D_QNAN, D_ANY, "R5");
    issue(3'd2, 1, D_QNAN, D_QNAN, "R5");
    // R6, R7, R8 single min/max with NaN
    issue(3'd3, 0, S_QNAN, S_ONE, "R6");
    issue(3'd4, 0, S_ONE, S_QNAN, "R6");
    issue(3'd3, 0, S_QNAN, S_QNAN, "R7");
    issue(3'd4, 0, S_QNAN, S_SNAN, "R8");
    // R10 classification
    issue(3'd3, 0, S_SNAN, S_TWO, "R10");
    issue(3'd4, 0, S_INF, S_TWO, "R10");
    issue(3'd0, 0, S_INF, S_INF, "R10");
    issue(3'd4, 1, D_SNAN, D_ONE, "R10");
    idle(2);
    // R9 double invalid
    issue(3'd3, 1, D_QNAN, D_ANY, "R9");
    writeSts(6'd0, "R11");
    issue(3'd4, 1, D_ANY, D_QNAN, "R9");
    writeSts(6'd0, "R11");
    issue(3'd3, 1, D_QNAN, D_QNAN, "R7");
    issue(3'd4, 1, D_QNAN, D_SNAN, "R9");
    // R2 upper bits ignored, reserved opcodes
    issue(3'd4, 0, 64'hDEAD_BEEF_3F80_0000, 64'hFFFF_FFFF_4000_0000, "R2");
    issue(3'd0, 0, 64'h1234_5678_3F80_0000, 64'h0000_0001_3F80_0000, "R2");
    issue(3'd5, 1, D_ONE, D_ANY, "R2");
    issue(3'd7, 1, D_QNAN, D_QNAN, "R2");
    issue(3'd6, 0, S_ONE, S_TWO, "R2");
    idle(3);
    // R11 status writes
    writeSts(6'b101011, "R11");
    idle(2);
    issue(3'd3, 0, S_QNAN, S_QNAN, "R11");
    writeSts(6'b000000, "R11");
    stsWrEn = 1'b1; stsWrData = 6'b010000;
    issue(3'd4, 1, D_QNAN, D_ONE, "R11");
    stsWrEn = 1'b0;
    stsWrEn = 1'b1; stsWrData = 6'b000100;
    issue(3'd4, 0, S_QNAN, S_ONE, "R11");
    stsWrEn = 1'b0;
    // R1 back-to-back and hold
    issue(3'd1, 1, D_ONE, D_NEG2, "R1");
    issue(3'd3, 1, D_ONE, D_NEG2, "R1");
    idle(4);
    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual still running, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule